// File: doc/BRIEF.md
# Stopwatch Run/Stop Controller

This block sits in front of a stopwatch counter chain and decides when the counters advance and when they are zeroed. It watches a single active-low push button and a clear request, and it produces two controls: a count-enable level and a one-cycle synchronous clear pulse.

The button goes through a short synchronizer chain before the state machine sees it. A start or stop takes effect only after a full press and release of the button. Pressing alone changes nothing at the outputs. Each completed press-and-release flips the watch between running and stopped.

The clear request is acted on only while the watch is stopped and the button is not held. It is edge-sensitive: one rising edge of the request gives one clear pulse. A request that rises while the watch is running or while the button is held is dropped. It is not remembered.

The reset is synchronous and active low. It parks the controller in the stopped state with the counters held clear.

Top module: `swatch_ctrl`

## Requirements
- R1: While `rst_n` is low, `cnt_en` is 0 and `cnt_clr` is 1. At the first clock edge after `rst_n` returns high, with `clr_req` low, `cnt_clr` drops to 0 and the controller is stopped.
- R2: From stopped, driving `btn_n` low (pressed) leaves `cnt_en` at 0 for as long as the button is held. After `btn_n` returns high, `cnt_en` rises at the third rising clock edge: two synchronizer stages plus the state register.
- R3: From running, pressing the button keeps `cnt_en` at 1 while it is held. `cnt_en` falls at the third rising clock edge after `btn_n` returns high.
- R4: Successive complete press-and-release cycles alternate `cnt_en` between 1 and 0.
- R5: While stopped with the button released, a rising edge of `clr_req` (active high) makes `cnt_clr` high for exactly one cycle, starting at the first rising clock edge after the edge of `clr_req`.
- R6: A `clr_req` edge that arrives while running, or while the button is held, produces no `cnt_clr` pulse. The pulse does not appear later either, even if `clr_req` stays high after the watch stops.
- R7: `cnt_clr` is never high while `cnt_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_n | input | 1 | Raw start/stop button, 0 = pressed, asynchronous |
| clr_req | input | 1 | Clear request, active high, synchronous |
| cnt_en | output | 1 | Counter enable, 1 = counting |
| cnt_clr | output | 1 | One-cycle synchronous counter clear |

## Verification
There are three ways the state machine can be in the wrong state, and each shows up at the ports quickly:
- A lost or extra transition appears as a `cnt_en` level that disagrees with the parity of completed press cycles. It is visible at the third edge after the release that should have caused the change.
- Confusing a press state with its neighbouring steady state shows up as `cnt_en` moving on the press instead of on the release. This is caught within three cycles of the press.
- A wrong clear qualifier, or a latched clear request, shows up as a `cnt_clr` pulse while running or after a stop. A clear pulse longer than one cycle is exposed one edge later.

// File: rtl/swatch_pkg.sv
// Package: shared state encoding for the stopwatch run/stop controller.
// Assumes: two-bit encoding is enough for the four control states.
package swatch_pkg;

    typedef enum logic [1:0] {
        ST_STOPPED   = 2'd0,
        ST_ARM_RUN   = 2'd1,
        ST_RUNNING   = 2'd2,
        ST_ARM_STOP  = 2'd3
    } sw_state_t;

endpackage

// File: rtl/swatch_sync.sv
// Module: swatch_sync
// Brings an asynchronous level into the clock domain through STAGES flops.
// Assumes: input is a slow mechanical level; RST_VAL is its idle value.
module swatch_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    // Shift the raw level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[LAST-1:0], d_async};
        end
    end

    assign q_sync = chain_q[LAST];

endmodule

// File: rtl/swatch_fsm.sv
// Module: swatch_fsm
// Four-state run/stop controller. A state change happens on button release.
// Clear is edge-qualified and honoured only in the stopped, released state.
// Assumes: btn_rel is already synchronous, 1 = released.
module swatch_fsm
    import swatch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic btn_rel,
    input  logic clr_req,
    output logic cnt_en,
    output logic cnt_clr
);

    sw_state_t state_q, state_d;
    logic      clr_prev_q;
    logic      clr_q;
    logic      clr_edge;

    // Next-state decode: enter arm states on press, leave them on release.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED:  if (!btn_rel) state_d = ST_ARM_RUN;
            ST_ARM_RUN:  if (btn_rel)  state_d = ST_RUNNING;
            ST_RUNNING:  if (!btn_rel) state_d = ST_ARM_STOP;
            ST_ARM_STOP: if (btn_rel)  state_d = ST_STOPPED;
            default:                   state_d = ST_STOPPED;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    assign clr_edge = clr_req && !clr_prev_q;

    // Clear pulse: forced by reset, then one cycle per qualified request edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_prev_q <= 1'b0;
            clr_q      <= 1'b1;
        end else begin
            clr_prev_q <= clr_req;
            clr_q      <= clr_edge && (state_q == ST_STOPPED) && btn_rel;
        end
    end

    // Counting continues through the stop-arm state until release.
    assign cnt_en  = (state_q == ST_RUNNING) || (state_q == ST_ARM_STOP);
    assign cnt_clr = clr_q;

    // R2: counting starts only after the synchronized button was seen released.
    p_start_on_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnt_en) |-> $past(btn_rel))
        else $error("p_start_on_release_r2");

    // R3: a press while running keeps the watch counting.
    p_hold_counts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUNNING) |=> cnt_en)
        else $error("p_hold_counts_r3");

    // R4: the stopped state can only be left toward the run-arm state.
    p_legal_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOPPED) |=> (state_q inside {ST_STOPPED, ST_ARM_RUN}))
        else $error("p_legal_exit_r4");

    // R5: a request-driven clear lasts exactly one cycle.
    p_clr_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clr && $past(rst_n)) |=> !cnt_clr)
        else $error("p_clr_one_cycle_r5");

    // R6: a clear pulse is always preceded by the stopped state.
    p_clr_from_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |-> ($past(state_q) == ST_STOPPED))
        else $error("p_clr_from_stop_r6");

    // R7: clear and enable never overlap.
    p_no_clr_running_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en |-> !cnt_clr)
        else $error("p_no_clr_running_r7");

endmodule

// File: rtl/swatch_ctrl.sv
// Module: swatch_ctrl (top)
// Run/stop and clear control for a stopwatch counter chain.
// Assumes: btn_n is a raw active-low button; clr_req is synchronous.
module swatch_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n,
    input  logic clr_req,
    output logic cnt_en,
    output logic cnt_clr
);

    logic btn_rel_s;

    swatch_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (btn_n),
        .q_sync  (btn_rel_s)
    );

    swatch_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .btn_rel (btn_rel_s),
        .clr_req (clr_req),
        .cnt_en  (cnt_en),
        .cnt_clr (cnt_clr)
    );

    // R1: while reset is held the counters are cleared and stopped.
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (cnt_clr && !cnt_en))
        else $error("p_reset_state_r1");

endmodule

// File: tb/swatch_ctrl_tb.sv
module swatch_ctrl_tb;

    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn_n = 1'b1;
    logic clr_req = 1'b0;
    logic cnt_en;
    logic cnt_clr;

    int n_tests = 0;
    int n_fail  = 0;

    swatch_ctrl u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .btn_n   (btn_n),
        .clr_req (clr_req),
        .cnt_en  (cnt_en),
        .cnt_clr (cnt_clr)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Full press and release; the outputs settle three edges after release.
    task automatic press_release();
        btn_n = 1'b0;
        step(4);
        btn_n = 1'b1;
        step(4);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(3);
        chk("R1", "cnt_clr in reset", cnt_clr, 1'b1);
        chk("R1", "cnt_en in reset", cnt_en, 1'b0);
        rst_n = 1'b1;
        step(1);
        chk("R1", "cnt_clr after release", cnt_clr, 1'b0);
        chk("R1", "cnt_en after release", cnt_en, 1'b0);
    endtask

    task automatic t_start();
        btn_n = 1'b0;
        step(4);
        chk("R2", "cnt_en on press only", cnt_en, 1'b0);
        step(6);
        chk("R2", "cnt_en while held", cnt_en, 1'b0);
        btn_n = 1'b1;
        step(2);
        chk("R2", "cnt_en two edges after release", cnt_en, 1'b0);
        step(1);
        chk("R2", "cnt_en three edges after release", cnt_en, 1'b1);
    endtask

    task automatic t_stop();
        btn_n = 1'b0;
        step(6);
        chk("R3", "cnt_en while stop held", cnt_en, 1'b1);
        btn_n = 1'b1;
        step(2);
        chk("R3", "cnt_en two edges after release", cnt_en, 1'b1);
        step(1);
        chk("R3", "cnt_en three edges after release", cnt_en, 1'b0);
    endtask

    task automatic t_alternate();
        for (int i = 0; i < 4; i++) begin
            press_release();
            chk("R4", "alternation", cnt_en, (i % 2 == 0) ? 1'b1 : 1'b0);
        end
    endtask

    task automatic t_clear_stopped();
        chk("R5", "stopped before clear", cnt_en, 1'b0);
        clr_req = 1'b1;
        step(1);
        chk("R5", "clear pulse first cycle", cnt_clr, 1'b1);
        step(1);
        chk("R5", "clear pulse ends", cnt_clr, 1'b0);
        step(4);
        chk("R5", "held request no repeat", cnt_clr, 1'b0);
        clr_req = 1'b0;
        step(2);
    endtask

    task automatic t_clear_running();
        press_release();
        chk("R6", "running before clear", cnt_en, 1'b1);
        clr_req = 1'b1;
        step(1);
        chk("R6", "no clear while running", cnt_clr, 1'b0);
        chk("R7", "enable stays high", cnt_en, 1'b1);
        step(2);
        press_release();
        chk("R6", "stopped with request held", cnt_en, 1'b0);
        chk("R6", "no latched clear", cnt_clr, 1'b0);
        step(3);
        chk("R6", "still no latched clear", cnt_clr, 1'b0);
        clr_req = 1'b0;
        step(1);
        clr_req = 1'b1;
        step(1);
        chk("R6", "fresh edge clears", cnt_clr, 1'b1);
        clr_req = 1'b0;
        step(2);
    endtask

    task automatic t_clear_pressed();
        btn_n = 1'b0;
        step(4);
        clr_req = 1'b1;
        step(1);
        chk("R6", "no clear while button held", cnt_clr, 1'b0);
        chk("R7", "enable low while arming", cnt_en, 1'b0);
        clr_req = 1'b0;
        btn_n = 1'b1;
        step(4);
        chk("R6", "running after arm", cnt_en, 1'b1);
        chk("R7", "no clear while running", cnt_clr, 1'b0);
        press_release();
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        step(1);
        t_reset();
        t_start();
        t_stop();
        t_alternate();
        t_clear_stopped();
        t_clear_running();
        t_clear_pressed();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule